// File: doc/BRIEF.md
# Timed AXI-Stream Stimulus Replayer

This block turns a flat stream of 32-bit words into AXI-Stream beats with controlled timing. The words hold stimulus records back to back. A record is a TDATA value split into whole 32-bit words, followed by one attribute word. The attribute word gives the number of idle cycles TVALID must stay low before that beat, and whether TLAST goes with the beat. A small deserializer separates the data words from the attribute word and writes them into two parallel queues. An output sequencer then replays the beats on the master port and inserts the gaps that each record asks for.

A test environment uses the block to drive a design under test with handshake timing that is deliberately not ideal. It can add gaps of any length between beats and mark TLAST on any beat it chooses. A running count of completed transfers is available on a port. An enable input pauses replay, and a synchronous reset returns the block to its empty state.

Top module: `stim_replay`

## Requirements
- R1: A record is DATA_WORDS input words carrying TDATA, least significant word first, followed by one attribute word. The next record starts on the very next input word, with no padding between records.
- R2: In the attribute word, bits [15:0] are the delay D and bit 16 requests TLAST on that beat. Bits [31:17] have no effect.
- R3: When the next record is already queued at a handshake, TVALID is low for exactly D cycles before the next beat is shown. D = 0 gives back-to-back beats.
- R4: When the queue is empty and a record arrives, TVALID rises on the (D+1)-th rising edge after the edge that accepts its attribute word.
- R5: Once TVALID is high, TVALID, TDATA and TLAST stay unchanged until a cycle in which TREADY is high.
- R6: TLAST can be set on any number of beats in a run, including beats in the middle of the run.
- R7: Data words are always accepted. s_ready is low only when an attribute word is offered while DEPTH records are already queued, and no record is lost while the queue is full.
- R8: beat_count increases by one on each cycle with TVALID and TREADY both high, and holds its value otherwise.
- R9: While en is low, m_tvalid is low, no record is taken from the queue, gap counting pauses and beat_count holds. When en returns high, the pending beat is shown again unchanged.
- R10: A synchronous reset empties the queue, drops any partly received record, clears beat_count and forces m_tvalid low, with s_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Replay enable; low freezes the output side |
| s_word | input | 32 | Incoming record word |
| s_valid | input | 1 | s_word is valid |
| s_ready | output | 1 | Block accepts s_word |
| m_tdata | output | DATA_WORDS*32 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the consumer |
| m_tlast | output | 1 | Stream last marker |
| beat_count | output | CNT_W | Number of completed transfers |

## Verification
The hardest condition to reach is an attribute word that arrives while the queue is already full. Only then does s_ready drop, and the record must still be stored intact once space appears. The bench reaches it by keeping en low so that nothing drains. It loads DEPTH records, then offers the data words and the attribute word of one more record. After that it opens replay and confirms that the extra beat comes out last with its data unchanged. Gap lengths are measured by counting low-TVALID cycles between handshakes while TREADY is held high.

// File: rtl/stim_replay.sv
module stim_replay #(
  parameter int DATA_WORDS = 2,
  parameter int DEPTH      = 8,
  parameter int CNT_W      = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [31:0]             s_word,
  input  logic                    s_valid,
  output logic                    s_ready,
  output logic [DATA_WORDS*32-1:0] m_tdata,
  output logic                    m_tvalid,
  input  logic                    m_tready,
  output logic                    m_tlast,
  output logic [CNT_W-1:0]        beat_count
);
  localparam int TW = DATA_WORDS * 32;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IW = $clog2(DATA_WORDS + 1);
  localparam logic [IW-1:0] ATTR_IDX = IW'(DATA_WORDS);
  localparam logic [AW:0]   FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_EMPTY, S_GAP, S_SHOW} ostate_t;

  // deserializer
  logic [IW-1:0] widx;
  logic [TW-1:0] asm_q;
  logic          is_attr, take, push;

  // queues
  logic [TW-1:0] dmem [DEPTH];
  logic [16:0]   amem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   fill;
  logic          empty, pop;

  // output side
  ostate_t       st;
  logic [15:0]   gap;
  logic [TW-1:0] td;
  logic          tl;
  logic [CNT_W-1:0] beats;
  logic [15:0]   rd_delay;
  logic          rd_last;
  logic          unused_flags;

  assign unused_flags = ^s_word[31:17];

  assign is_attr = (widx == ATTR_IDX);
  assign s_ready = !is_attr || (fill != FULL_LVL);
  assign take    = s_valid && s_ready;
  assign push    = take && is_attr;
  assign empty   = (fill == '0);

  always_ff @(posedge clk) begin
    if (rst) widx <= '0;
    else if (take) widx <= is_attr ? '0 : widx + IW'(1);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DATA_WORDS; k++)
      if (take && widx == IW'(k)) asm_q[k*32 +: 32] <= s_word;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      dmem[wptr] <= asm_q;
      amem[wptr] <= {s_word[16], s_word[15:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + AW'(1);
      if (pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + AW'(1);
      case ({push, pop})
        2'b10:   fill <= fill + (AW+1)'(1);
        2'b01:   fill <= fill - (AW+1)'(1);
        default: ;
      endcase
    end
  end

  assign rd_delay = amem[rptr][15:0];
  assign rd_last  = amem[rptr][16];
  assign pop = en && !empty && ((st == S_EMPTY) || (st == S_SHOW && m_tready));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_EMPTY;
      gap   <= '0;
      td    <= '0;
      tl    <= 1'b0;
      beats <= '0;
    end else if (pop) begin
      td <= dmem[rptr];
      tl <= rd_last;
      if (st == S_SHOW) beats <= beats + CNT_W'(1);
      if (rd_delay == 16'd0) st <= S_SHOW;
      else begin
        gap <= rd_delay - 16'd1;
        st  <= S_GAP;
      end
    end else if (en) begin
      case (st)
        S_GAP:
          if (gap == 16'd0) st <= S_SHOW;
          else gap <= gap - 16'd1;
        S_SHOW:
          if (m_tready) begin
            beats <= beats + CNT_W'(1);
            st    <= S_EMPTY;
          end
        default: ;
      endcase
    end
  end

  assign m_tvalid   = en && (st == S_SHOW);
  assign m_tdata    = td;
  assign m_tlast    = tl;
  assign beat_count = beats;
endmodule

// File: rtl/stim_replay_chk.sv
module stim_replay_chk #(
  parameter int DEPTH = 8,
  parameter int TW    = 64,
  parameter int AW    = 3,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             m_tvalid,
  input logic             m_tready,
  input logic [TW-1:0]    m_tdata,
  input logic             m_tlast,
  input logic [CNT_W-1:0] beat_count,
  input logic             push,
  input logic             pop,
  input logic [AW:0]      fill,
  input logic [1:0]       st,
  input logic [15:0]      gap
);
  // R5
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> (!en || (m_tvalid && $stable(m_tdata) && $stable(m_tlast))));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (fill < (AW+1)'(DEPTH) || pop));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> (fill != '0));

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(m_tvalid && m_tready) |=> $stable(beat_count));

  // R9
  freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(st) && $stable(gap) && $stable(beat_count)));
endmodule

bind stim_replay stim_replay_chk #(.DEPTH(DEPTH), .TW(TW), .AW(AW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .en(en), .m_tvalid(m_tvalid), .m_tready(m_tready),
  .m_tdata(m_tdata), .m_tlast(m_tlast), .beat_count(beat_count),
  .push(push), .pop(pop), .fill(fill), .st(st), .gap(gap)
);

// File: tb/stim_replay_tb_top.sv
module stim_replay_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 2;
  localparam int DEPTH = 8;
  localparam int NV = 8;

  localparam logic [63:0] V_DATA [NV] = '{
    64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h1111_2222_3333_4444,
    64'hA5A5_5A5A_0F0F_F0F0, 64'h0000_0000_FFFF_FFFF, 64'hDEAD_BEEF_CAFE_F00D,
    64'h8000_0000_0000_0001, 64'h7654_3210_0BAD_C0DE};
  localparam logic [15:0] V_FLAGS [NV] = '{16'h0000, 16'h0001, 16'h0000, 16'h0002,
                                           16'h0001, 16'h0000, 16'h0003, 16'h0001};
  localparam logic [15:0] V_DELAY [NV] = '{16'd0, 16'd0, 16'd1, 16'd3, 16'd0, 16'd2, 16'd5, 16'd0};
  localparam bit V_LAST [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [31:0] s_word = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [63:0] m_tdata;
  logic m_tvalid, m_tlast;
  logic m_tready = 1'b0;
  logic [31:0] beat_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  stim_replay #(.DATA_WORDS(DW), .DEPTH(DEPTH), .CNT_W(32)) dut_i (
    .clk(clk), .rst(rst), .en(en), .s_word(s_word), .s_valid(s_valid), .s_ready(s_ready),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
    .beat_count(beat_count));

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  bit mon_on = 1'b0;
  int n_got = 0;
  int gap_run = 0;
  logic [63:0] got_d [32];
  bit got_l [32];
  int got_gap [32];

  always @(negedge clk) begin
    if (mon_on) begin
      if (m_tvalid && m_tready) begin
        if (n_got < 32) begin
          got_d[n_got] = m_tdata;
          got_l[n_got] = m_tlast;
          got_gap[n_got] = gap_run;
        end
        n_got++;
        gap_run = 0;
      end else if (!m_tvalid) begin
        gap_run++;
      end
    end
  end

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic mon_clear();
    n_got = 0;
    gap_run = 0;
  endtask

  task automatic push_word(input logic [31:0] w);
    s_word = w;
    s_valid = 1'b1;
    while (!s_ready) tick();
    tick();
    s_valid = 1'b0;
  endtask

  task automatic push_rec(input logic [63:0] d, input logic [15:0] fl, input logic [15:0] dl);
    push_word(d[31:0]);
    push_word(d[63:32]);
    push_word({fl, dl});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick();
    do_reset();
    // R10 reset state
    check("R10", "tvalid after reset", m_tvalid, 0);
    check("R10", "beat_count after reset", beat_count, 0);
    check("R10", "s_ready after reset", s_ready, 1);

    // Table walk: R1 R2 R3 R6 R8
    en = 1'b0;
    m_tready = 1'b1;
    for (int i = 0; i < NV; i++) push_rec(V_DATA[i], V_FLAGS[i], V_DELAY[i]);
    mon_clear();
    mon_on = 1'b1;
    en = 1'b1;
    repeat (60) tick();
    check("R8", "table beats seen", n_got, NV);
    check("R8", "table beat_count", beat_count, NV);
    for (int i = 0; i < NV; i++) begin
      check("R1", $sformatf("tdata beat %0d", i), got_d[i], V_DATA[i]);
      check("R2_R6", $sformatf("tlast beat %0d", i), got_l[i], V_LAST[i]);
      if (i > 0) check("R3", $sformatf("gap before beat %0d", i), got_gap[i], V_DELAY[i]);
    end
    mon_on = 1'b0;

    // R4 timing from idle, R5 backpressure
    do_reset();
    en = 1'b1;
    m_tready = 1'b0;
    push_rec(64'hCAFE_0000_0000_BEEF, 16'h0001, 16'd2);
    check("R4", "tvalid edge+0", m_tvalid, 0);
    tick();
    check("R4", "tvalid edge+1", m_tvalid, 0);
    tick();
    check("R4", "tvalid edge+2", m_tvalid, 0);
    tick();
    check("R4", "tvalid edge+3", m_tvalid, 1);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R5", "tvalid held", m_tvalid, 1);
      check("R5", "tdata held", m_tdata, 64'hCAFE_0000_0000_BEEF);
      check("R5", "tlast held", m_tlast, 1);
      check("R8", "no count while stalled", beat_count, 0);
    end
    m_tready = 1'b1;
    tick();
    check("R8", "count after handshake", beat_count, 1);
    check("R3", "tvalid low when queue empty", m_tvalid, 0);

    // R9 enable freeze
    do_reset();
    en = 1'b1;
    m_tready = 1'b0;
    push_rec(64'h0BAD_F00D_1234_5678, 16'h0000, 16'd0);
    tick();
    tick();
    check("R9", "beat shown before freeze", m_tvalid, 1);
    en = 1'b0;
    m_tready = 1'b1;
    tick();
    check("R9", "tvalid low while disabled", m_tvalid, 0);
    repeat (3) tick();
    check("R9", "count held while disabled", beat_count, 0);
    en = 1'b1;
    #1;
    check("R9", "tvalid back on enable", m_tvalid, 1);
    check("R9", "same tdata after enable", m_tdata, 64'h0BAD_F00D_1234_5678);
    tick();
    check("R9", "count after resume", beat_count, 1);

    // R7 full queue
    do_reset();
    en = 1'b0;
    m_tready = 1'b1;
    for (int i = 0; i < DEPTH; i++) push_rec(64'(i + 1), 16'h0000, 16'd0);
    check("R7", "ready for data word when full", s_ready, 1);
    push_word(32'h9999_0009);
    check("R7", "ready for second data word when full", s_ready, 1);
    push_word(32'h9999_1009);
    s_word = {16'h0001, 16'd0};
    s_valid = 1'b1;
    tick();
    check("R7", "ready low for attribute when full", s_ready, 0);
    tick();
    check("R7", "ready stays low", s_ready, 0);
    mon_clear();
    mon_on = 1'b1;
    en = 1'b1;
    while (!s_ready) tick();
    tick();
    s_valid = 1'b0;
    repeat (40) tick();
    check("R7", "beats after full", n_got, DEPTH + 1);
    check("R7", "held record data", got_d[DEPTH], 64'h9999_1009_9999_0009);
    check("R7", "held record last", got_l[DEPTH], 1);
    check("R8", "count after full test", beat_count, DEPTH + 1);
    mon_on = 1'b0;

    // R10 reset mid-run with partial record
    en = 1'b0;
    push_rec(64'h1, 16'h0000, 16'd0);
    push_rec(64'h2, 16'h0000, 16'd0);
    push_word(32'hAAAA_AAAA);
    do_reset();
    check("R10", "tvalid after mid reset", m_tvalid, 0);
    check("R10", "count after mid reset", beat_count, 0);
    check("R10", "s_ready after mid reset", s_ready, 1);
    mon_clear();
    mon_on = 1'b1;
    en = 1'b1;
    push_rec(64'h5555_6666_7777_8888, 16'h0001, 16'd0);
    repeat (10) tick();
    check("R10", "only new record replayed", n_got, 1);
    check("R10", "new record data", got_d[0], 64'h5555_6666_7777_8888);
    check("R10", "new record last", got_l[0], 1);
    mon_on = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule